// File: doc/BRIEF.md
# Panel Timing Generator Serial Control Slave

This block is a write-only serial control slave that sits beside an LCD panel timing generator. A host sends 8-bit command words over a synchronous serial link with an active-low select. The upper three bits of each word name a register and the lower five bits carry its data. Only two registers act here. One picks full or quarter display resolution. The other sets the low five bits of a 6-bit backlight intensity. The remaining six addresses are accepted and have no effect.

The top bit of the intensity does not come from the serial link. It comes from a separate discrete control pin with inverted sense. A separate power-enable pin gates the backlight. The block outputs three things: the raw intensity, an effective backlight level that reads zero whenever power is off, and the resolution mode. While power is on, it also emits a one-cycle pulse each time the effective level changes. It never drives data back to the host.

The serial inputs are sampled with the system clock. Serial clock, select and data each pass through a two-stage synchronizer, so the serial clock must stay well below the system clock rate.

Top module: `panel_tgen_slave`

## Requirements
- R1: A word is shifted in MSB first, one bit per rising edge of `ser_clk` while `ser_cs_n` is low. Word bits 7:5 give the register address and bits 4:0 give the data.
- R2: A word with address 2 loads its data into `intensity[4:0]` and leaves `intensity[5]` unchanged.
- R3: `intensity[5]` follows `bit5_ctl` inverted: a high pin clears it and a low pin sets it.
- R4: A word with address 0 sets `quarter_mode` to 1 when its data is nonzero and to 0 when its data is zero.
- R5: Words with addresses 1, 3, 4, 5, 6 or 7 change neither `intensity` nor `quarter_mode`.
- R6: After reset, `intensity` is 0x20 (while `bit5_ctl` is low), `bl_level` is 0, `quarter_mode` is 0 and `level_change` is 0.
- R7: `bl_level` equals `intensity` while `bl_power` is high and is 0 while it is low. It is therefore also 0 when the intensity is 0.
- R8: When `ser_cs_n` rises after fewer than 8 bits, those bits are discarded. The next word starts aligned at its own first bit.
- R9: `level_change` pulses high for exactly one cycle for each change of `bl_level` while `bl_power` is high. It never pulses while `bl_power` is low.
- R10: `ser_dout` is 0 at all times.
- R11: Several words may be sent within one select-low period. Each one commits after every group of 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_din | input | 1 | Serial data into the slave |
| ser_dout | output | 1 | Serial data to the host, always 0 |
| bit5_ctl | input | 1 | Inverted source of intensity bit 5 |
| bl_power | input | 1 | Backlight power enable |
| intensity | output | 6 | Current backlight intensity |
| bl_level | output | 6 | Effective backlight level, gated by power |
| quarter_mode | output | 1 | 1 selects quarter resolution |
| level_change | output | 1 | One-cycle pulse on each effective level change while powered |

## Verification
The duty register is swept through all 32 data values. Each sweep runs with power on and power off and with both levels of the bit-5 pin. This separates the serial field from the inverted pin and the gating from the raw value. Every address is written with nonzero and zero data, which shows that only addresses 0 and 2 have an effect. Truncated words followed by full words, and two words sent under one select, show how words are framed. The bench counts change pulses over each sequence and compares the count with the number of effective-level changes it computes itself.

// File: rtl/panel_tgen_pkg.sv
package panel_tgen_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int INT_W  = DATA_W + 1;

  localparam logic [ADDR_W-1:0] A_RESCTL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;

  function automatic cmd_word_t split_word(input logic [WORD_W-1:0] w);
    cmd_word_t c;
    c.addr = w[WORD_W-1 -: ADDR_W];
    c.data = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [INT_W-1:0] gate_level(input logic pwr,
                                                  input logic [INT_W-1:0] lvl);
    return pwr ? lvl : '0;
  endfunction
endpackage

// File: rtl/ptg_serial_rx.sv
module ptg_serial_rx
  import panel_tgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_cs_n,
  input  logic              ser_din,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] clk_sync, cs_sync, din_sync;
  logic                   clk_prev;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      cs_sync  <= '1;
      din_sync <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], ser_cs_n};
      din_sync <= {din_sync[SYNC_STAGES-2:0], ser_din};
      clk_prev <= clk_sync[SYNC_STAGES-1];
    end
  end

  wire sel_active = !cs_sync[SYNC_STAGES-1];
  wire bit_rise   = clk_sync[SYNC_STAGES-1] && !clk_prev;
  wire bit_in     = din_sync[SYNC_STAGES-1];
  wire last_bit   = (bit_cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      word_stb <= 1'b0;
      word_q   <= '0;
    end else begin
      word_stb <= 1'b0;
      if (!sel_active) begin
        bit_cnt <= '0;
      end else if (bit_rise) begin
        shreg <= {shreg[WORD_W-2:0], bit_in};
        if (last_bit) begin
          word_q   <= {shreg[WORD_W-2:0], bit_in};
          word_stb <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> bit_cnt == '0) else $error("deselect kept partial bits"); // R8
  AST_STB_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(bit_rise && sel_active)) else $error("word without edge"); // R1
endmodule

// File: rtl/ptg_ctrl_regs.sv
module ptg_ctrl_regs
  import panel_tgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              bit5_ctl,
  output logic [INT_W-1:0]  intensity,
  output logic              quarter_mode
);
  cmd_word_t         cmd;
  logic [DATA_W-1:0] duty;
  logic              top_bit;

  assign cmd       = split_word(wr_word);
  assign intensity = {top_bit, duty};

  wire wr_duty = wr_stb && (cmd.addr == A_DUTY);
  wire wr_res  = wr_stb && (cmd.addr == A_RESCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty         <= '0;
      top_bit      <= 1'b1;
      quarter_mode <= 1'b0;
    end else begin
      top_bit <= !bit5_ctl;
      if (wr_duty) duty <= cmd.data;
      if (wr_res)  quarter_mode <= |cmd.data;
    end
  end

  AST_DUTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_duty |=> duty == $past(cmd.data)) else $error("duty not loaded"); // R2
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_duty |=> $stable(duty)) else $error("duty changed"); // R5
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_res |=> quarter_mode == ($past(cmd.data) != '0)) else $error("mode wrong"); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_res |=> $stable(quarter_mode)) else $error("mode changed"); // R5
  AST_BIT5_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> top_bit == !$past(bit5_ctl)) else $error("bit5 not inverted"); // R3
endmodule

// File: rtl/ptg_backlight_gate.sv
module ptg_backlight_gate
  import panel_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bl_power,
  input  logic [INT_W-1:0] intensity,
  output logic [INT_W-1:0] bl_level,
  output logic             level_change
);
  logic             pwr_q;
  logic [INT_W-1:0] next_level;

  assign next_level = gate_level(pwr_q, intensity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q        <= 1'b0;
      bl_level     <= '0;
      level_change <= 1'b0;
    end else begin
      pwr_q        <= bl_power;
      bl_level     <= next_level;
      level_change <= pwr_q && (next_level != bl_level);
    end
  end

  AST_NO_PULSE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> !level_change) else $error("pulse while off"); // R9
  AST_OFF_IS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> bl_level == '0) else $error("level while off"); // R7
  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_change |-> bl_level != $past(bl_level)) else $error("pulse without change"); // R9
endmodule

// File: rtl/panel_tgen_slave.sv
module panel_tgen_slave
  import panel_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_cs_n,
  input  logic             ser_din,
  output logic             ser_dout,
  input  logic             bit5_ctl,
  input  logic             bl_power,
  output logic [INT_W-1:0] intensity,
  output logic [INT_W-1:0] bl_level,
  output logic             quarter_mode,
  output logic             level_change
);
  logic              word_stb;
  logic [WORD_W-1:0] word_q;

  assign ser_dout = 1'b0;

  ptg_serial_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .word_stb(word_stb), .word_q(word_q)
  );

  ptg_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(word_stb), .wr_word(word_q),
    .bit5_ctl(bit5_ctl), .intensity(intensity), .quarter_mode(quarter_mode)
  );

  ptg_backlight_gate u_gate (
    .clk(clk), .rst_n(rst_n), .bl_power(bl_power), .intensity(intensity),
    .bl_level(bl_level), .level_change(level_change)
  );
endmodule

// File: tb/panel_tgen_slave_bench.sv
`timescale 1ns/1ps
module panel_tgen_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0;
  logic bit5_ctl = 1'b0, bl_power = 1'b0;
  logic ser_dout, quarter_mode, level_change;
  logic [5:0] intensity, bl_level;

  int checks = 0, errors = 0, pulses = 0;
  logic [4:0] m_duty = '0;
  logic       m_mode = 1'b0;

  always #4 clk = ~clk;

  panel_tgen_slave u_panel_tgen_slave (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .bit5_ctl(bit5_ctl),
    .bl_power(bl_power), .intensity(intensity), .bl_level(bl_level),
    .quarter_mode(quarter_mode), .level_change(level_change)
  );

  always @(posedge clk) if (rst_n && level_change) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] w, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      ser_din = w[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      if (ser_dout !== 1'b0) check("R10 dout", ser_dout, 0);
    end
  endtask

  task automatic frame(input logic [7:0] w, input int nbits);
    ser_cs_n = 1'b0;
    wait_clk(4);
    send_bits(w, nbits);
    wait_clk(4);
    ser_cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic put(input logic [2:0] a, input logic [4:0] d);
    frame({a, d}, 8);
    if (a == 3'd2) m_duty = d;
    if (a == 3'd0) m_mode = (d != 0);
  endtask

  function automatic int exp_int();
    return {!bit5_ctl, m_duty};
  endfunction

  function automatic int exp_lvl();
    return bl_power ? exp_int() : 0;
  endfunction

  task automatic check_state(input string req);
    check({req, " intensity"}, intensity, exp_int());
    check({req, " level"}, bl_level, exp_lvl());
    check({req, " mode"}, quarter_mode, m_mode);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_pulses;
    int prev;
    wait_clk(3);
    check("R6 reset intensity", intensity, 32);
    check("R6 reset level", bl_level, 0);
    check("R6 reset mode", quarter_mode, 0);
    check("R6 reset pulse", level_change, 0);
    rst_n = 1'b1;
    wait_clk(4);
    check_state("R6 after reset");

    // R2 R7 R9: duty sweep, both power states and both bit-5 pin levels
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        bl_power = p[0];
        bit5_ctl = b[0];
        wait_clk(6);
        pulses = 0;
        exp_pulses = 0;
        prev = exp_lvl();
        for (int d = 0; d < 32; d++) begin
          put(3'd2, 5'(d));
          check_state("R2 R3 R7 duty sweep");
          if (bl_power && exp_lvl() != prev) exp_pulses++;
          prev = exp_lvl();
        end
        check("R9 pulse count duty sweep", pulses, exp_pulses);
      end
    end

    // R3 R9: toggle the bit-5 pin while powered
    bl_power = 1'b1; bit5_ctl = 1'b0; wait_clk(6);
    put(3'd2, 5'd9);
    pulses = 0;
    bit5_ctl = 1'b1; wait_clk(6);
    check_state("R3 pin high");
    bit5_ctl = 1'b0; wait_clk(6);
    check_state("R3 pin low");
    check("R9 pin toggles", pulses, 2);

    // R7 R9: power off gives no pulse, power on gives one
    pulses = 0;
    bl_power = 1'b0; wait_clk(6);
    check_state("R7 power off");
    check("R9 no pulse at power off", pulses, 0);
    bit5_ctl = 1'b1; wait_clk(6);
    put(3'd2, 5'd3);
    check("R9 no pulse while off", pulses, 0);
    bl_power = 1'b1; wait_clk(6);
    check_state("R7 power on");
    check("R9 one pulse at power on", pulses, 1);
    put(3'd2, 5'd0);
    check_state("R7 zero intensity dark");
    check("R9 pulse to zero", pulses, 2);

    // R4: resolution register
    put(3'd0, 5'd1);  check_state("R4 quarter 1");
    put(3'd0, 5'd0);  check_state("R4 full");
    put(3'd0, 5'd16); check_state("R4 quarter 16");
    put(3'd0, 5'd31); check_state("R4 quarter 31");

    // R5: other addresses ignored, with all-ones and all-zero data
    put(3'd2, 5'd21);
    for (int a = 1; a < 8; a++) begin
      if (a == 2) continue;
      put(3'(a), 5'd31); check_state("R5 ignored addr ones");
      put(3'(a), 5'd0);  check_state("R5 ignored addr zeros");
    end

    // R8: partial words discarded, next word aligned
    for (int n = 1; n < 8; n++) begin
      frame({3'd2, 5'd7}, n);
      check_state("R8 partial discarded");
      put(3'd2, 5'(n + 10));
      check_state("R8 aligned after partial");
    end
    frame({3'd0, 5'd0}, 7);
    check_state("R8 partial mode write discarded");

    // R1 R11: two words under one select, MSB first
    ser_cs_n = 1'b0; wait_clk(4);
    send_bits({3'd2, 5'b10110}, 8);
    send_bits({3'd0, 5'b00000}, 8);
    wait_clk(4); ser_cs_n = 1'b1; wait_clk(8);
    m_duty = 5'b10110; m_mode = 1'b0;
    check_state("R1 R11 two words one frame");
    check("R1 msb first duty", intensity[4:0], 22);
    check("R10 dout idle", ser_dout, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule